// File: doc/BRIEF.md
# Bit-Plane Serial Dot-Product Engine

This block turns a stream of bitwise-AND rows into an unsigned multi-bit dot product. Both operand vectors are held as bit-planes, one row for each bit index across all elements. A pair of rows, one input plane and one weight plane, is ANDed upstream. For each such pair the engine counts the ones in the row and weights that count by two raised to the sum of the two bit indices. It then adds the weighted count into a running sum. Summing over every plane pair gives the same result as multiplying each element pair and adding the products.

A start pulse opens a computation. The engine then asks for plane pairs one at a time and publishes each pair's indices, so the memory array knows which rows to AND. Each returned row is taken through a valid/ready handshake. The popcount is registered in one stage and added with its shift in the next. After the last pair is added, the engine raises a one-cycle done flag with the final sum. The state machine has four named states: IDLE, RUN, DRAIN and DONE. Its transitions are IDLE→RUN on start, RUN→RUN on each accepted row except the last, RUN→DRAIN on the last accepted row, DRAIN→DONE unconditionally, and DONE→IDLE unconditionally.

Top module: `bitplane_mac`

## Requirements
- R1: While reset is held and in the first cycle after it, `row_ready` and `done` are 0 and `result` is 0.
- R2: A `start` pulse seen in IDLE moves the engine to RUN. In the next cycle `result` is 0 and the requested pair is (input bit 0, weight bit 0).
- R3: Pairs are requested with the input bit index as the outer loop and the weight bit index as the inner loop, both ascending. That is 8 x 8 = 64 pairs with the defaults. The engine advances by one pair for each row accepted, meaning `row_valid` and `row_ready` are both high at a clock edge.
- R4: While `row_ready` is high and `row_valid` is low, the requested pair indices and `row_ready` hold for the next cycle.
- R5: Each accepted row adds its popcount shifted left by (input bit + weight bit) to `result`. The addition becomes visible two cycles after the accepting edge.
- R6: `done` is high for exactly one cycle, two cycles after the 64th row is accepted. In that cycle `result` equals the unsigned sum over all elements of input times weight.
- R7: The accumulator does not overflow for 512 elements that are all 255 on both operands, where the expected result is 33,292,800.
- R8: A `start` pulse outside IDLE is ignored. The pair sequence and the accumulated sum continue unchanged.
- R9: Outside a computation, `row_ready` stays low and `result` keeps the last sum until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new dot product (honoured in IDLE only) |
| row_valid | input | 1 | AND row on `row_data` is valid |
| row_data | input | ROW_W (512) | One AND row, one bit per element |
| row_ready | output | 1 | Engine requests and accepts the pair shown on the index outputs |
| req_ibit | output | 3 | Input bit-plane index of the requested pair |
| req_wbit | output | 3 | Weight bit-plane index of the requested pair |
| done | output | 1 | One-cycle flag: `result` holds the finished dot product |
| result | output | ACC_W (26) | Running and final unsigned dot product |

## Verification
On every cycle, the assertions check several properties. Done is a single-cycle pulse followed by idle. A stalled request holds its pair. Each accepted row steps the weight index and wraps into the input index in the right order. A sequence always opens at pair (0,0). The sum never decreases during a run and stays still while idle. The arithmetic cannot be shown by properties and is left to the bench's scenarios. Those cover the popcount and shift weighting, the exact final value against a direct integer dot product, the all-zero and all-255 extremes, and the ignoring of start pulses mid-run under random stalls.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } bpm_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bpm_popcount.sv
module bpm_popcount #(
    parameter int ROW_W = 512,
    parameter int GROUP = 16,
    parameter int CNT_W = $clog2(ROW_W + 1)
) (
    input  logic [ROW_W-1:0] row_i,
    output logic [CNT_W-1:0] count_o
);
    localparam int NGRP = ROW_W / GROUP;
    localparam int GW   = $clog2(GROUP + 1);

    logic [GW-1:0] grp_cnt [NGRP];

    // First level: one small adder chain per group of row bits.
    for (genvar g = 0; g < NGRP; g++) begin : g_group
        always_comb begin
            grp_cnt[g] = '0;
            for (int b = 0; b < GROUP; b++) begin
                grp_cnt[g] = grp_cnt[g] + {{(GW-1){1'b0}}, row_i[g*GROUP + b]};
            end
        end
    end

    // Second level: sum of the group counts.
    always_comb begin
        count_o = '0;
        for (int g = 0; g < NGRP; g++) begin
            count_o = count_o + CNT_W'(grp_cnt[g]);
        end
    end

endmodule

// File: rtl/bpm_sequencer.sv
module bpm_sequencer
    import bpm_pkg::*;
#(
    parameter int IN_BITS = 8,
    parameter int WT_BITS = 8,
    parameter int IB_W    = idx_width(IN_BITS),
    parameter int WB_W    = idx_width(WT_BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            row_valid_i,
    output logic            ready_o,
    output logic            fire_o,
    output logic            clear_o,
    output logic            done_o,
    output logic [IB_W-1:0] ibit_o,
    output logic [WB_W-1:0] wbit_o
);
    localparam logic [IB_W-1:0] IB_LAST = IB_W'(IN_BITS - 1);
    localparam logic [WB_W-1:0] WB_LAST = WB_W'(WT_BITS - 1);

    bpm_state_e      state_q, state_d;
    logic [IB_W-1:0] ibit_q;
    logic [WB_W-1:0] wbit_q;
    logic            last_pair;
    logic            accept;

    assign last_pair = (ibit_q == IB_LAST) && (wbit_q == WB_LAST);
    assign accept    = (state_q == ST_RUN) && row_valid_i;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_RUN;
            ST_RUN:   if (accept && last_pair) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pair counters: weight index inner, input index outer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibit_q <= '0;
            wbit_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            ibit_q <= '0;
            wbit_q <= '0;
        end else if (accept && !last_pair) begin
            if (wbit_q == WB_LAST) begin
                wbit_q <= '0;
                ibit_q <= ibit_q + 1'b1;
            end else begin
                wbit_q <= wbit_q + 1'b1;
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        ready_o = 1'b0;
        done_o  = 1'b0;
        clear_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  clear_o = start_i;
            ST_RUN:   ready_o = 1'b1;
            ST_DRAIN: ;
            ST_DONE:  done_o  = 1'b1;
            default:  ;
        endcase
    end

    assign fire_o = accept;
    assign ibit_o = ibit_q;
    assign wbit_o = wbit_q;

endmodule

// File: rtl/bpm_shift_acc.sv
module bpm_shift_acc #(
    parameter int CNT_W = 10,
    parameter int SH_W  = 4,
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             fire_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [SH_W-1:0]  shamt_i,
    output logic [ACC_W-1:0] acc_o
);
    logic             vld_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  sh_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] term;

    // Stage 1: capture the popcount and its weight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            vld_q <= fire_i;
            if (fire_i) begin
                cnt_q <= count_i;
                sh_q  <= shamt_i;
            end
        end
    end

    assign term = ACC_W'(cnt_q) << sh_q;

    // Stage 2: weighted add.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (clear_i) acc_q <= '0;
        else if (vld_q)   acc_q <= acc_q + term;
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/bitplane_mac.sv
module bitplane_mac
    import bpm_pkg::*;
#(
    parameter int ROW_W   = 512,
    parameter int IN_BITS = 8,
    parameter int WT_BITS = 8,
    parameter int ACC_W   = $clog2(ROW_W + 1) + IN_BITS + WT_BITS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic                                row_valid,
    input  logic [ROW_W-1:0]                    row_data,
    output logic                                row_ready,
    output logic [idx_width(IN_BITS)-1:0]       req_ibit,
    output logic [idx_width(WT_BITS)-1:0]       req_wbit,
    output logic                                done,
    output logic [ACC_W-1:0]                    result
);
    localparam int IB_W  = idx_width(IN_BITS);
    localparam int WB_W  = idx_width(WT_BITS);
    localparam int CNT_W = $clog2(ROW_W + 1);
    localparam int SH_W  = idx_width(IN_BITS + WT_BITS - 1);

    logic             fire;
    logic             clear;
    logic [CNT_W-1:0] count;
    logic [SH_W-1:0]  shamt;

    bpm_sequencer #(
        .IN_BITS (IN_BITS),
        .WT_BITS (WT_BITS),
        .IB_W    (IB_W),
        .WB_W    (WB_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .row_valid_i (row_valid),
        .ready_o     (row_ready),
        .fire_o      (fire),
        .clear_o     (clear),
        .done_o      (done),
        .ibit_o      (req_ibit),
        .wbit_o      (req_wbit)
    );

    bpm_popcount #(
        .ROW_W (ROW_W),
        .GROUP (16),
        .CNT_W (CNT_W)
    ) u_pop (
        .row_i   (row_data),
        .count_o (count)
    );

    assign shamt = SH_W'(req_ibit) + SH_W'(req_wbit);

    bpm_shift_acc #(
        .CNT_W (CNT_W),
        .SH_W  (SH_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .fire_i  (fire),
        .count_i (count),
        .shamt_i (shamt),
        .acc_o   (result)
    );

endmodule

// File: rtl/bitplane_mac_chk.sv
module bitplane_mac_chk #(
    parameter int IB_W    = 3,
    parameter int WB_W    = 3,
    parameter int ACC_W   = 26,
    parameter int IN_BITS = 8,
    parameter int WT_BITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             row_valid,
    input logic             row_ready,
    input logic [IB_W-1:0]  req_ibit,
    input logic [WB_W-1:0]  req_wbit,
    input logic             done,
    input logic [ACC_W-1:0] result
);
    logic last_req;
    assign last_req = (req_ibit == IB_W'(IN_BITS - 1)) && (req_wbit == WB_W'(WT_BITS - 1));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !row_ready));

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ready && !row_valid) |=> (row_ready && $stable(req_ibit) && $stable(req_wbit)));

    p_pair_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ready && row_valid && !last_req) |=>
            (row_ready &&
             (($past(req_wbit) == WB_W'(WT_BITS - 1)) ?
                 (req_wbit == '0 && req_ibit == $past(req_ibit) + 1'b1) :
                 (req_wbit == $past(req_wbit) + 1'b1 && req_ibit == $past(req_ibit)))));

    p_first_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_ready) |-> (req_ibit == '0 && req_wbit == '0 && result == '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(row_ready) |-> (result >= $past(result)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_ready && !done && !start && !$past(row_ready)) |=> $stable(result));

endmodule

bind bitplane_mac bitplane_mac_chk #(
    .IB_W    (IB_W),
    .WB_W    (WB_W),
    .ACC_W   (ACC_W),
    .IN_BITS (IN_BITS),
    .WT_BITS (WT_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .row_valid (row_valid),
    .row_ready (row_ready),
    .req_ibit  (req_ibit),
    .req_wbit  (req_wbit),
    .done      (done),
    .result    (result)
);

// File: tb/bitplane_mac_bench.sv
module bitplane_mac_bench;
    localparam int ROW_W = 512;
    localparam int NB    = 8;
    localparam int ACC_W = 26;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             row_valid = 1'b0;
    logic [ROW_W-1:0] row_data = '0;
    logic             row_ready;
    logic [2:0]       req_ibit;
    logic [2:0]       req_wbit;
    logic             done;
    logic [ACC_W-1:0] result;

    always #4 clk = ~clk;

    bitplane_mac u_bitplane_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .row_valid (row_valid),
        .row_data  (row_data),
        .row_ready (row_ready),
        .req_ibit  (req_ibit),
        .req_wbit  (req_wbit),
        .done      (done),
        .result    (result)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cyc   = 0;

    logic [7:0] xv [ROW_W];
    logic [7:0] wv [ROW_W];
    longint     golden;

    // Behavioural reference: 0 idle, 1 run, 2 drain, 3 done.
    int     m_phase = 0;
    int     m_pair  = 0;
    longint m_acc   = 0;
    bit     m_pend  = 0;
    longint m_pval  = 0;

    function automatic logic [ROW_W-1:0] plane_and(int pair);
        logic [ROW_W-1:0] r;
        for (int k = 0; k < ROW_W; k++) r[k] = xv[k][pair / NB] & wv[k][pair % NB];
        return r;
    endfunction

    function automatic longint ones(logic [ROW_W-1:0] r);
        longint c = 0;
        for (int k = 0; k < ROW_W; k++) c += longint'(r[k]);
        return c;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R3 row_ready", longint'(row_ready), longint'(m_phase == 1));
        if (m_phase == 1) begin
            check("R3 req_ibit", longint'(req_ibit), longint'(m_pair / NB));
            check("R3 req_wbit", longint'(req_wbit), longint'(m_pair % NB));
        end
        check("R6 done", longint'(done), longint'(m_phase == 3));
        check("R5 result", longint'(result), m_acc);
        if (m_phase == 3) check("R6 dot product", longint'(result), golden);
    endtask

    task automatic tick(bit st, bit vl);
        logic [ROW_W-1:0] r;
        longint nacc;
        r = plane_and(m_pair);
        start = st;
        row_valid = vl;
        row_data = r;
        @(posedge clk);
        cyc++;
        nacc = m_acc + (m_pend ? m_pval : 0);
        m_pend = 0;
        case (m_phase)
            0: if (st) begin nacc = 0; m_pair = 0; m_phase = 1; end
            1: if (vl) begin
                   m_pend = 1;
                   m_pval = ones(r) << ((m_pair / NB) + (m_pair % NB));
                   if (m_pair == NB*NB - 1) m_phase = 2;
                   else m_pair++;
               end
            2: m_phase = 3;
            default: m_phase = 0;
        endcase
        m_acc = nacc;
        @(negedge clk);
        compare_all();
    endtask

    function automatic void compute_golden();
        golden = 0;
        for (int k = 0; k < ROW_W; k++) golden += longint'(xv[k]) * longint'(wv[k]);
    endfunction

    // stall_pct: chance of row_valid low; noise: stray start pulses mid-run (R8).
    task automatic run_one(int stall_pct, bit noise);
        compute_golden();
        tick(1'b1, 1'b0);                         // R2 start
        check("R2 first pair", longint'({req_ibit, req_wbit}), 0);
        check("R2 cleared", longint'(result), 0);
        while (m_phase != 0) begin
            bit vl = ($urandom_range(99) >= stall_pct);
            bit st = noise && ($urandom_range(9) == 0);
            tick(st, vl);
        end
        // R9: idle cycles with valid toggling, result must hold.
        for (int t = 0; t < 3; t++) tick(1'b0, t[0]);
        check("R9 hold", longint'(result), golden);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < ROW_W; k++) begin xv[k] = '0; wv[k] = '0; end
        repeat (3) @(negedge clk);
        check("R1 row_ready", longint'(row_ready), 0);
        check("R1 done", longint'(done), 0);
        check("R1 result", longint'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset result", longint'(result), 0);

        // All zero operands.
        run_one(0, 1'b0);
        // All 255 operands: R7 upper bound.
        for (int k = 0; k < ROW_W; k++) begin xv[k] = 8'hFF; wv[k] = 8'hFF; end
        run_one(0, 1'b0);
        check("R7 max", longint'(result), 64'd33292800);
        // Random operands, stalls R4 and stray starts R8.
        for (int n = 0; n < 6; n++) begin
            for (int k = 0; k < ROW_W; k++) begin
                xv[k] = 8'($urandom);
                wv[k] = (n == 1) ? 8'd1 : 8'($urandom);
            end
            run_one((n % 3) * 25, n >= 2);
        end
        // One-hot weights in the top bit plane.
        for (int k = 0; k < ROW_W; k++) begin xv[k] = 8'($urandom); wv[k] = 8'h80; end
        run_one(40, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule